// File: doc/BRIEF.md
# Dual-Issue Integer/FP Pairing Logic

This block is the issue stage of a two-wide in-order core. Every cycle fetch offers an aligned pair. The left half carries an integer-side instruction, which is an integer op, an FP load or an FP store. The right half carries either a floating-point ALU op or a no-op. The block holds the pair in its own slot register. It decides in each cycle whether nothing, only the left instruction, or both instructions leave. It tells fetch to freeze while any part of the pair is still waiting.

Readiness of FP operands is tracked by a small scoreboard. It keeps one down-counter per FP register. When a producer issues, its latency is loaded into the counter of its destination register. An FP ALU consumer needs the counter at zero. A store consumer may go one step earlier. A producer must not finish ahead of an older write to the same register. Issue within the pair stays in order: the right instruction never leaves before the left one. If only the right instruction is blocked, the left one goes and the right one stays in the slot alone.

Top module: `pair_issue_top`

## Requirements
- R1: After synchronous reset, `fetch_hold_o`, `int_issue_o` and `fp_issue_o` are low and every FP register counts as ready, so an FP op presented first issues at once.
- R2: Pair encoding is: `int_kind_i` 0 = no-op, 1 = integer op, 2 = FP load (writes `int_freg_i`), 3 = FP store (reads `int_freg_i`); `fp_op_i` 1 = FP ALU op (writes `fp_dst_i`, reads `fp_srca_i`/`fp_srcb_i`), 0 = no-op. A pair is latched at a rising edge where `pair_vld_i` is high and `fetch_hold_o` is low, and it is decided in the following cycle. An issue decision made in cycle t shows on `int_issue_o`/`fp_issue_o` in cycle t+1. A pair without hazards issues both halves in one cycle.
- R3: The right instruction issues only in a cycle where the left instruction of the same pair also issues, or has already issued. While the left one stalls, neither issues and `fetch_hold_o` is high.
- R4: If the left instruction issues and the right one cannot, the left one issues alone. The right one stays and is decided alone in the next cycles, and `fetch_hold_o` stays high until it issues.
- R5: An FP ALU op that reads the result of an FP ALU op issued in cycle t issues no earlier than cycle t+4.
- R6: A store that reads the result of an FP ALU op issued in cycle t issues no earlier than cycle t+3.
- R7: An FP ALU op that reads the register loaded by a load issued in cycle t issues no earlier than t+2. It can therefore use neither a load in its own pair nor one in the pair before it.
- R8: A store that reads the register loaded by a load issued in cycle t may issue in cycle t+1.
- R9: A producer waits until an older in-flight write to its destination would not complete after it. A load to a register written by an FP ALU op issued in cycle t issues no earlier than t+3.
- R10: No-op halves and cycles with `pair_vld_i` low never stall and never raise an issue enable.
- R11: While `fetch_hold_o` is high, the values on the pair inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pair_vld_i | input | 1 | Fetch offers a pair this cycle |
| int_kind_i | input | 2 | Left-half kind (no-op, integer, load, store) |
| int_freg_i | input | $clog2(NREG) | FP register written by a load or read by a store |
| fp_op_i | input | 1 | Right half holds an FP ALU op |
| fp_dst_i | input | $clog2(NREG) | FP ALU destination register |
| fp_srca_i | input | $clog2(NREG) | FP ALU first source register |
| fp_srcb_i | input | $clog2(NREG) | FP ALU second source register |
| fetch_hold_o | output | 1 | Fetch must keep its pair; the slot is not free |
| int_issue_o | output | 1 | Left instruction issued in the previous cycle |
| fp_issue_o | output | 1 | Right instruction issued in the previous cycle |

## Verification
The bench builds the block with eight FP registers and the default latencies of 3 and 1 with a store margin of 1. With so few registers, random pairs hit read-after-write and write-after-write collisions on nearly every few cycles. This reaches the same-pair load conflict, lone right halves that must wait, and the highest counter values with both writers aimed at one register. Directed sequences before the random run place each latency edge in an exact cycle.

// File: rtl/pair_issue_pkg.sv
package pair_issue_pkg;

  typedef enum logic [1:0] {
    LK_NOP   = 2'd0,
    LK_INT   = 2'd1,
    LK_LOAD  = 2'd2,
    LK_STORE = 2'd3
  } lkind_e;

  function automatic int unsigned imax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fp_ready_board.sv
module fp_ready_board #(
  parameter int unsigned NREG = 32,
  parameter int unsigned CW   = 2,
  parameter int unsigned NQ   = 4,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   w0_en,
  input  logic [AW-1:0]          w0_idx,
  input  logic [CW-1:0]          w0_val,
  input  logic                   w1_en,
  input  logic [AW-1:0]          w1_idx,
  input  logic [CW-1:0]          w1_val,
  input  logic [NQ-1:0][AW-1:0]  q_idx,
  output logic [NQ-1:0][CW-1:0]  q_cnt
);

  logic [CW-1:0] cnt [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          hit0, hit1;
    logic [CW-1:0] nv;
    assign hit0 = w0_en && (w0_idx == AW'(g));
    assign hit1 = w1_en && (w1_idx == AW'(g));
    assign nv   = (hit1 && (!hit0 || (w1_val >= w0_val))) ? w1_val : w0_val;

    always_ff @(posedge clk) begin
      if (rst)                cnt[g] <= '0;
      else if (hit0 || hit1)  cnt[g] <= nv;
      else if (cnt[g] != '0)  cnt[g] <= cnt[g] - 1'b1;
    end

    AST_CNT_DECAY: assert property (@(posedge clk) disable iff (rst)
      (!hit0 && !hit1 && (cnt[g] != '0)) |=> (cnt[g] == $past(cnt[g]) - 1'b1)); // R5
  end

  for (genvar q = 0; q < NQ; q++) begin : g_q
    assign q_cnt[q] = cnt[q_idx[q]];
  end

endmodule

// File: rtl/pair_arbiter.sv
module pair_arbiter
  import pair_issue_pkg::*;
#(
  parameter int unsigned AW       = 5,
  parameter int unsigned CW       = 2,
  parameter int unsigned FPOP_LAT = 3,
  parameter int unsigned LOAD_LAT = 1,
  parameter int unsigned ST_SLACK = 1
) (
  input  logic          lv,
  input  lkind_e        lk,
  input  logic [AW-1:0] lreg,
  input  logic          rv,
  input  logic [AW-1:0] ra,
  input  logic [AW-1:0] rb,
  input  logic [CW-1:0] cnt_l,
  input  logic [CW-1:0] cnt_a,
  input  logic [CW-1:0] cnt_b,
  input  logic [CW-1:0] cnt_d,
  output logic          go_l,
  output logic          go_r
);

  localparam logic [CW-1:0] FPOP_C  = CW'(FPOP_LAT);
  localparam logic [CW-1:0] LOAD_C  = CW'(LOAD_LAT);
  localparam logic [CW-1:0] STORE_C = CW'(ST_SLACK);

  logic l_ok, r_ok, pair_raw;

  always_comb begin
    unique case (lk)
      LK_LOAD:  l_ok = (cnt_l <= LOAD_C);
      LK_STORE: l_ok = (cnt_l <= STORE_C);
      default:  l_ok = 1'b1;
    endcase
    go_l     = !lv || l_ok;
    pair_raw = lv && (lk == LK_LOAD) && ((ra == lreg) || (rb == lreg));
    r_ok     = (cnt_a == '0) && (cnt_b == '0) && (cnt_d <= FPOP_C) && !pair_raw;
    go_r     = go_l && (!rv || r_ok);
  end

endmodule

// File: rtl/pair_issue_top.sv
module pair_issue_top
  import pair_issue_pkg::*;
#(
  parameter int unsigned NREG     = 32,
  parameter int unsigned FPOP_LAT = 3,
  parameter int unsigned LOAD_LAT = 1,
  parameter int unsigned ST_SLACK = 1,
  localparam int unsigned AW      = $clog2(NREG),
  localparam int unsigned CW      = $clog2(imax(FPOP_LAT, LOAD_LAT) + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pair_vld_i,
  input  logic [1:0]    int_kind_i,
  input  logic [AW-1:0] int_freg_i,
  input  logic          fp_op_i,
  input  logic [AW-1:0] fp_dst_i,
  input  logic [AW-1:0] fp_srca_i,
  input  logic [AW-1:0] fp_srcb_i,
  output logic          fetch_hold_o,
  output logic          int_issue_o,
  output logic          fp_issue_o
);

  localparam int unsigned NQ = 4;

  logic          lv, rv;
  lkind_e        lk;
  logic [AW-1:0] lreg, rd, ra, rb;
  logic          go_l, go_r;
  logic [NQ-1:0][AW-1:0] q_idx;
  logic [NQ-1:0][CW-1:0] q_cnt;
  logic          w0_en, w1_en;

  assign q_idx = {rd, rb, ra, lreg};
  assign w0_en = go_l && lv && (lk == LK_LOAD);
  assign w1_en = go_r && rv;

  fp_ready_board #(.NREG(NREG), .CW(CW), .NQ(NQ)) board_i (
    .clk    (clk),
    .rst    (rst),
    .w0_en  (w0_en),
    .w0_idx (lreg),
    .w0_val (CW'(LOAD_LAT)),
    .w1_en  (w1_en),
    .w1_idx (rd),
    .w1_val (CW'(FPOP_LAT)),
    .q_idx  (q_idx),
    .q_cnt  (q_cnt)
  );

  pair_arbiter #(
    .AW(AW), .CW(CW), .FPOP_LAT(FPOP_LAT), .LOAD_LAT(LOAD_LAT), .ST_SLACK(ST_SLACK)
  ) arb_i (
    .lv    (lv),
    .lk    (lk),
    .lreg  (lreg),
    .rv    (rv),
    .ra    (ra),
    .rb    (rb),
    .cnt_l (q_cnt[0]),
    .cnt_a (q_cnt[1]),
    .cnt_b (q_cnt[2]),
    .cnt_d (q_cnt[3]),
    .go_l  (go_l),
    .go_r  (go_r)
  );

  assign fetch_hold_o = (lv && !go_l) || (rv && !go_r);

  always_ff @(posedge clk) begin
    if (rst) begin
      lv          <= 1'b0;
      rv          <= 1'b0;
      lk          <= LK_NOP;
      lreg        <= '0;
      rd          <= '0;
      ra          <= '0;
      rb          <= '0;
      int_issue_o <= 1'b0;
      fp_issue_o  <= 1'b0;
    end else begin
      int_issue_o <= go_l && lv;
      fp_issue_o  <= go_r && rv;
      if (!fetch_hold_o) begin
        lv   <= pair_vld_i && (int_kind_i != 2'd0);
        rv   <= pair_vld_i && fp_op_i;
        lk   <= lkind_e'(int_kind_i);
        lreg <= int_freg_i;
        rd   <= fp_dst_i;
        ra   <= fp_srca_i;
        rb   <= fp_srcb_i;
      end else if (go_l) begin
        lv <= 1'b0;
      end
    end
  end

  AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (lv && rv && !go_l) |=> !fp_issue_o); // R3

  AST_HOLD_KEEPS_RIGHT: assert property (@(posedge clk) disable iff (rst)
    fetch_hold_o |=> ($stable(rv) && $stable(rd) && $stable(ra) && $stable(rb))); // R11

  AST_SAME_PAIR_LOAD: assert property (@(posedge clk) disable iff (rst)
    (go_l && lv && (lk == LK_LOAD) && rv && ((ra == lreg) || (rb == lreg))) |=> !fp_issue_o); // R7

  AST_EMPTY_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!lv && !rv) |-> !fetch_hold_o); // R10

endmodule

// File: tb/pair_issue_top_tb.sv
module pair_issue_top_tb_top;

  localparam int PERIOD = 10;
  localparam int NR     = 8;
  localparam int AWT    = 3;

  typedef struct {
    bit    v;
    int    lk;
    int    lr;
    bit    rf;
    int    rd;
    int    ra;
    int    rb;
    string tag;
  } pr_t;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           pair_vld_i = 1'b0;
  logic [1:0]     int_kind_i = '0;
  logic [AWT-1:0] int_freg_i = '0;
  logic           fp_op_i = 1'b0;
  logic [AWT-1:0] fp_dst_i = '0, fp_srca_i = '0, fp_srcb_i = '0;
  logic           fetch_hold_o, int_issue_o, fp_issue_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(PERIOD/2) clk = ~clk;

  pair_issue_top #(.NREG(NR)) dut_i (
    .clk(clk), .rst(rst), .pair_vld_i(pair_vld_i), .int_kind_i(int_kind_i),
    .int_freg_i(int_freg_i), .fp_op_i(fp_op_i), .fp_dst_i(fp_dst_i),
    .fp_srca_i(fp_srca_i), .fp_srcb_i(fp_srcb_i), .fetch_hold_o(fetch_hold_o),
    .int_issue_o(int_issue_o), .fp_issue_o(fp_issue_o)
  );

  pr_t q[$];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic push(input bit v, input int lk, input int lr, input bit rf,
                      input int rd, input int ra, input int rb, input string tag);
    pr_t p;
    p.v = v; p.lk = lk; p.lr = lr; p.rf = rf; p.rd = rd; p.ra = ra; p.rb = rb; p.tag = tag;
    q.push_back(p);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int avail [NR];
    bit mlv, mrv;
    int mlk, mlr, mrd, mra, mrb;
    string mtag, ptag;
    bit p_int, p_fp, gl, gr, mh, garb, pgarb;
    int cyc;
    foreach (avail[i]) avail[i] = 0;
    mlv = 0; mrv = 0; mlk = 0; mlr = 0; mrd = 0; mra = 0; mrb = 0;
    mtag = "R1"; ptag = "R1"; p_int = 0; p_fp = 0; pgarb = 0; cyc = 0;

    // R2 plain pairs, R10 empty and no-op halves
    push(1, 1, 0, 1, 1, 2, 3, "R2");
    push(1, 2, 4, 1, 5, 6, 7, "R2");
    push(0, 0, 0, 0, 0, 0, 0, "R10");
    push(1, 0, 0, 0, 0, 0, 0, "R10");
    push(1, 0, 0, 1, 6, 0, 0, "R10");
    push(1, 3, 0, 0, 0, 0, 0, "R10");
    // R1: first FP op in this stretch reads registers never written
    // R5 fp -> fp
    push(1, 1, 0, 1, 1, 2, 3, "R5");
    push(1, 1, 0, 1, 2, 1, 3, "R5");
    push(0, 0, 0, 0, 0, 0, 0, "R5");
    push(0, 0, 0, 0, 0, 0, 0, "R5");
    push(0, 0, 0, 0, 0, 0, 0, "R5");
    push(0, 0, 0, 0, 0, 0, 0, "R5");
    // R6 fp -> store
    push(1, 1, 0, 1, 3, 0, 0, "R6");
    push(1, 3, 3, 0, 0, 0, 0, "R6");
    push(0, 0, 0, 0, 0, 0, 0, "R6");
    push(0, 0, 0, 0, 0, 0, 0, "R6");
    push(0, 0, 0, 0, 0, 0, 0, "R6");
    // R7 load feeding FP op in same pair, R4 lone right half
    push(1, 2, 4, 1, 5, 4, 4, "R7");
    push(1, 1, 0, 0, 0, 0, 0, "R4");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    // R7 load in previous pair
    push(1, 2, 6, 0, 0, 0, 0, "R7");
    push(1, 1, 0, 1, 7, 6, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    push(0, 0, 0, 0, 0, 0, 0, "R7");
    // R8 load -> store next cycle
    push(1, 2, 6, 0, 0, 0, 0, "R8");
    push(1, 3, 6, 0, 0, 0, 0, "R8");
    push(0, 0, 0, 0, 0, 0, 0, "R8");
    // R3 left stall blocks an independent right half
    push(1, 1, 0, 1, 7, 0, 0, "R3");
    push(1, 3, 7, 1, 1, 2, 2, "R3");
    push(0, 0, 0, 0, 0, 0, 0, "R3");
    push(0, 0, 0, 0, 0, 0, 0, "R3");
    push(0, 0, 0, 0, 0, 0, 0, "R3");
    push(0, 0, 0, 0, 0, 0, 0, "R3");
    // R9 WAW
    push(1, 1, 0, 1, 2, 0, 0, "R9");
    push(1, 2, 2, 0, 0, 0, 0, "R9");
    push(0, 0, 0, 0, 0, 0, 0, "R9");
    push(0, 0, 0, 0, 0, 0, 0, "R9");
    push(0, 0, 0, 0, 0, 0, 0, "R9");
    // random mix
    for (int i = 0; i < 3000; i++)
      push(($urandom % 10) != 0, int'($urandom % 4), int'($urandom % NR), ($urandom % 4) != 0,
           int'($urandom % NR), int'($urandom % NR), int'($urandom % NR), "R5");

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1", "hold after reset", fetch_hold_o, 0);
    chk("R1", "int enable after reset", int_issue_o, 0);
    chk("R1", "fp enable after reset", fp_issue_o, 0);
    #(PERIOD/2 - 1);
    @(negedge clk);

    while (q.size() > 0 || mlv || mrv) begin
      // model decision for this cycle (state only)
      gl = !mlv || (mlk == 1) || ((mlk == 2 || mlk == 3) && (avail[mlr] - cyc <= 1));
      gr = gl && (!mrv || ((avail[mra] <= cyc) && (avail[mrb] <= cyc) && (avail[mrd] - cyc <= 3) &&
                           !(mlv && mlk == 2 && (mra == mlr || mrb == mlr))));
      mh = (mlv && !gl) || (mrv && !gr);
      // drive: fetch keeps its pair; when held, drive junk to prove it is ignored
      garb = mh;
      if (mh) begin
        pair_vld_i = 1'b1;
        int_kind_i = 2'($urandom % 4);
        int_freg_i = AWT'($urandom % NR);
        fp_op_i    = 1'b1;
        fp_dst_i   = AWT'($urandom % NR);
        fp_srca_i  = AWT'($urandom % NR);
        fp_srcb_i  = AWT'($urandom % NR);
      end else if (q.size() > 0) begin
        pair_vld_i = q[0].v;
        int_kind_i = 2'(q[0].lk);
        int_freg_i = AWT'(q[0].lr);
        fp_op_i    = q[0].rf;
        fp_dst_i   = AWT'(q[0].rd);
        fp_srca_i  = AWT'(q[0].ra);
        fp_srcb_i  = AWT'(q[0].rb);
      end else begin
        pair_vld_i = 1'b0;
      end
      #1;
      chk(pgarb ? "R11" : mtag, "fetch_hold_o", fetch_hold_o, mh);
      chk(ptag, "int_issue_o", int_issue_o, p_int);
      chk(ptag, "fp_issue_o", fp_issue_o, p_fp);
      // model update at the coming edge
      if (gl && mlv && mlk == 2 && avail[mlr] < cyc + 2) avail[mlr] = cyc + 2;
      if (gr && mrv && avail[mrd] < cyc + 4) avail[mrd] = cyc + 4;
      p_int = gl && mlv;
      p_fp  = gr && mrv;
      ptag  = mtag;
      pgarb = garb;
      if (!mh) begin
        if (q.size() > 0) begin
          pr_t p;
          p = q.pop_front();
          mlv = p.v && (p.lk != 0);
          mrv = p.v && p.rf;
          mlk = p.lk; mlr = p.lr; mrd = p.rd; mra = p.ra; mrb = p.rb; mtag = p.tag;
        end else begin
          mlv = 0; mrv = 0;
        end
      end else if (gl) begin
        mlv = 0;
      end
      cyc++;
      @(negedge clk);
    end
    #1;
    chk(ptag, "int_issue_o final", int_issue_o, p_int);
    chk(ptag, "fp_issue_o final", fp_issue_o, p_fp);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule